// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel clock, given as an unsigned frequency in steps of 10 kHz, into the 13-bit program word that a serially loaded clock synthesizer expects. A one-cycle start strobe launches a calculation. The block first checks that the request lies within the synthesizer's reach. It then doubles the frequency until it falls inside the oscillator band, and each doubling doubles the post-divider. A single restoring divider, used twice in turn, derives the rounded feedback count. The block then packs the feedback count, the post-divider code and a constant stop pattern into the word.

The upstream logic must turn a pixel period into a frequency before it makes a request. A downstream shifter sends the finished word to the synthesizer. The result is presented with a one-cycle done pulse. The word, the post-divide ratio and the error flag hold their values until the next result replaces them.

Top module: `pclk_word_calc`

## Requirements
- R1: A request above 15938 ends one cycle after its start. At that point done is high, error is high, and the word and the post-divide ratio are 0.
- R2: A request below 1000 is rejected in the same way as R1. The values 1000 and 15938 are accepted.
- R3: The post-divide ratio output is the smallest of 1, 2, 4 or 8 that brings the request times the ratio to at least 8000. That product is the scaled frequency.
- R4: The feedback count equals floor((floor(S × 46000 / 1432) + 500) / 1000), where S is the scaled frequency.
- R5: Word bits 8:0 hold the feedback count minus 257.
- R6: Word bits 10:9 hold the post-divider code: 3 for a ratio of 1, 2 for 2, 1 for 4 and 0 for 8.
- R7: Word bits 12:11 are always 2'b11 in an accepted result.
- R8: Done is high for exactly one cycle per result. The word, the ratio and the error flag hold their values until the next result.
- R9: A start that arrives while a calculation is running has no effect. That calculation completes with its own result, and no second result follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| freq_i | input | 16 | Requested frequency in 10 kHz units |
| word_o | output | 13 | Packed program word |
| ratio_o | output | 4 | Chosen post-divide ratio (1, 2, 4, 8) |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | Request was out of range |

## Verification
The assertions assume that the divisor the controller hands the divider is never zero. They also assume that a request that passes the range check is at least 1000, so the scaled frequency reaches the band after no more than three doublings. The controller supplies only the constants 1432 and 1000 as divisors, so the first assumption holds. The bench never passes an out-of-range value to the datapath, because each request is either rejected or inside the accepted range. The stimulus covers both range edges, every doubling count and a restart that arrives during a calculation.

// File: rtl/pc_calc_pkg.sv
package pc_calc_pkg;

    parameter int FREQ_W    = 16;
    parameter int NUM_W     = 30;
    parameter int DEN_W     = 11;
    parameter int WORD_W    = 13;
    parameter int FB_W      = 10;

    parameter int F_MAX     = 15938;
    parameter int F_MIN     = 1000;
    parameter int BAND_LO   = 8000;
    parameter int REF_MUL   = 46000;
    parameter int REF_DIV   = 1432;
    parameter int ROUND_ADD = 500;
    parameter int ROUND_DIV = 1000;
    parameter int FB_OFFSET = 257;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCALE,
        S_DIV1,
        S_DIV2
    } calc_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [3:0]        ratio;
        logic              err;
    } calc_result_t;

    function automatic logic [WORD_W-1:0] pack_word(logic [FB_W-1:0] fb, logic [1:0] shifts);
        logic [FB_W-1:0] off;
        logic [1:0]      code;
        off  = fb - FB_W'(FB_OFFSET);
        code = 2'd3 - shifts;
        return {2'b11, code, off[8:0]};
    endfunction

endpackage

// File: rtl/pc_range_check.sv
module pc_range_check
    import pc_calc_pkg::*;
(
    input  logic [FREQ_W-1:0] freq_i,
    output logic              too_high_o,
    output logic              too_low_o
);

    always_comb begin
        too_high_o = (freq_i > FREQ_W'(F_MAX));
        too_low_o  = (freq_i < FREQ_W'(F_MIN));
    end

endmodule

// File: rtl/pc_scaler.sv
module pc_scaler
    import pc_calc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic [1:0]        shifts_o,
    output logic              ready_o
);

    logic [FREQ_W-1:0] freq_q;
    logic [1:0]        sh_q;
    logic              run_q;
    logic              in_band;

    assign in_band = (freq_q >= FREQ_W'(BAND_LO));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            freq_q <= '0;
            sh_q   <= '0;
            run_q  <= 1'b0;
        end else if (load_i) begin
            freq_q <= freq_i;
            sh_q   <= '0;
            run_q  <= 1'b1;
        end else if (run_q) begin
            if (in_band) begin
                run_q <= 1'b0;
            end else begin
                freq_q <= {freq_q[FREQ_W-2:0], 1'b0};
                sh_q   <= sh_q + 2'd1;
            end
        end
    end

    assign freq_o   = freq_q;
    assign shifts_o = sh_q;
    assign ready_o  = in_band;

    // R3
    band_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && in_band) |-> (freq_q < FREQ_W'(2*BAND_LO)));

    // R3
    shift_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && !in_band) |-> (sh_q != 2'd3));

endmodule

// File: rtl/pc_divider.sv
module pc_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] nq_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, nq_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            nq_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(NUM_W);
                rem_q  <= '0;
                den_q  <= den_i;
                nq_q   <= num_i;
            end else if (busy_q) begin
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                nq_q  <= {nq_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = nq_q;

    // R4
    rem_lt_den_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q |-> (rem_q < den_q));

endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc
    import pc_calc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic [FREQ_W-1:0]   freq_i,
    output logic [WORD_W-1:0]   word_o,
    output logic [3:0]          ratio_o,
    output logic                done_o,
    output logic                err_o
);

    calc_state_t  state_q;
    calc_result_t res_q;
    logic         done_q;

    logic              too_high, too_low;
    logic              sc_load, sc_ready;
    logic [FREQ_W-1:0] sc_freq;
    logic [1:0]        sc_shifts;

    logic              div_start, div_done;
    logic [NUM_W-1:0]  div_num, div_quot, prod;
    logic [DEN_W-1:0]  div_den;

    pc_range_check u_range (
        .freq_i     (freq_i),
        .too_high_o (too_high),
        .too_low_o  (too_low)
    );

    assign sc_load = (state_q == S_IDLE) && start_i && !too_high && !too_low;

    pc_scaler u_scaler (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (sc_load),
        .freq_i   (freq_i),
        .freq_o   (sc_freq),
        .shifts_o (sc_shifts),
        .ready_o  (sc_ready)
    );

    assign prod = NUM_W'(sc_freq) * NUM_W'(REF_MUL);

    always_comb begin
        div_start = 1'b0;
        div_num   = prod;
        div_den   = DEN_W'(REF_DIV);
        if (state_q == S_SCALE && sc_ready) begin
            div_start = 1'b1;
        end else if (state_q == S_DIV1 && div_done) begin
            div_start = 1'b1;
            div_num   = div_quot + NUM_W'(ROUND_ADD);
            div_den   = DEN_W'(ROUND_DIV);
        end
    end

    pc_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= S_IDLE;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (too_high || too_low) begin
                            res_q.word  <= '0;
                            res_q.ratio <= '0;
                            res_q.err   <= 1'b1;
                            done_q      <= 1'b1;
                        end else begin
                            state_q <= S_SCALE;
                        end
                    end
                end
                S_SCALE: begin
                    if (sc_ready) state_q <= S_DIV1;
                end
                S_DIV1: begin
                    if (div_done) state_q <= S_DIV2;
                end
                S_DIV2: begin
                    if (div_done) begin
                        res_q.word  <= pack_word(div_quot[FB_W-1:0], sc_shifts);
                        res_q.ratio <= 4'd1 << sc_shifts;
                        res_q.err   <= 1'b0;
                        done_q      <= 1'b1;
                        state_q     <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign word_o  = res_q.word;
    assign ratio_o = res_q.ratio;
    assign err_o   = res_q.err;
    assign done_o  = done_q;

    // R1
    high_reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_IDLE && start_i && freq_i > FREQ_W'(F_MAX)) |=> (done_o && err_o));

    // R2
    low_reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_IDLE && start_i && freq_i < FREQ_W'(F_MIN)) |=> (done_o && err_o));

    // R5
    fb_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !err_o) |-> (word_o[8:0] <= 9'd257));

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R9
    restart_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_DIV1 || state_q == S_DIV2) |=> $stable(sc_freq));

endmodule

// File: tb/pclk_word_calc_tb_top.sv
module pclk_word_calc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] freq = '0;
    logic [12:0] word;
    logic [3:0]  ratio;
    logic        done, err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pclk_word_calc dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .freq_i  (freq),
        .word_o  (word),
        .ratio_o (ratio),
        .done_o  (done),
        .err_o   (err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_for(input int f, output bit e_err, output int e_word, output int e_ratio);
        longint s, q, fb;
        int p, code;
        e_err = (f > 15938) || (f < 1000);
        if (e_err) begin
            e_word = 0; e_ratio = 0;
        end else begin
            s = f; p = 1;
            while (s < 8000) begin s = s * 2; p = p * 2; end
            q  = (s * 46000) / 1432;
            fb = (q + 500) / 1000;
            code = (p == 1) ? 3 : (p == 2) ? 2 : (p == 4) ? 1 : 0;
            e_word  = 32'h1800 | (code << 9) | int'(fb - 257);
            e_ratio = p;
        end
    endtask

    task automatic pulse_start(input int f);
        @(negedge clk);
        freq  = 16'(f);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_request(input int f);
        bit e_err, seen;
        int e_word, e_ratio;
        expect_for(f, e_err, e_word, e_ratio);
        pulse_start(f);
        wait_done(seen);
        chk("R8 done seen", seen, 1);
        chk(e_err ? (f > 15938 ? "R1 err" : "R2 err") : "R2 accept", err, e_err);
        chk("R3 ratio", ratio, e_ratio);
        chk("R5 feedback field", word[8:0], e_word & 32'h1FF);
        chk("R4 full word", word, e_word);
        if (!e_err) begin
            chk("R6 code field", word[10:9], (e_word >> 9) & 3);
            chk("R7 stop field", word[12:11], 3);
        end
        @(negedge clk);
        chk("R8 single pulse", done, 0);
        chk("R8 hold word", word, e_word);
    endtask

    task automatic test_reset();
        chk("R8 reset done", done, 0);
        chk("R8 reset err", err, 0);
        chk("R8 reset word", word, 0);
        chk("R8 reset ratio", ratio, 0);
    endtask

    task automatic test_rejects();
        run_request(15939);
        run_request(65535);
        run_request(999);
        run_request(0);
    endtask

    task automatic test_edges();
        run_request(1000);
        run_request(15938);
        run_request(8000);
        run_request(7999);
    endtask

    task automatic test_ratios();
        run_request(4000);
        run_request(3999);
        run_request(2000);
        run_request(1999);
        run_request(12345);
        run_request(5432);
    endtask

    task automatic test_restart_ignored();
        bit e_err, seen;
        int e_word, e_ratio;
        expect_for(3100, e_err, e_word, e_ratio);
        pulse_start(3100);
        repeat (10) @(negedge clk);
        pulse_start(14000);
        repeat (20) @(negedge clk);
        pulse_start(500);
        wait_done(seen);
        chk("R9 first result", word, e_word);
        chk("R9 first ratio", ratio, e_ratio);
        chk("R9 no error", err, 0);
        @(negedge clk);
        seen = 0;
        for (int i = 0; i < 120; i++) begin
            if (done) seen = 1;
            @(negedge clk);
        end
        chk("R9 no second result", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_rejects();
        test_edges();
        test_ratios();
        test_restart_ignored();
        run_request(9000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule